// File: doc/BRIEF.md
# Display Raster Timing Generator

The block produces the horizontal sync, vertical sync and data-enable strobes of a parallel display interface, together with the column and row of the pixel currently in the visible area. Each line is divided into four intervals: visible pixels, front porch, sync pulse and back porch. Each frame is divided into the same four intervals, counted in lines. Software programs the length of each interval and four polarity inversion bits on a working set of inputs. These values reach the running raster only at a start, or through a shadow-load request that takes effect at a frame boundary. As a result, a mode change never tears a frame.

Clearing the enable does not stop the raster at once. The current frame runs to its last pixel, and the enable status reads back as set until that happens, so software polls it as a handshake. A vertical blanking status bit sets on the first line after the visible area and is cleared by writing 1 to it. It is combined with an interrupt enable to drive an interrupt line. A synchronous soft reset returns all timing state to idle so the block can be set up again. All interval lengths must be programmed as 1 or more.

Top module: `disp_timing_gen`

## Requirements
- R1: A line lasts h_active+h_front+h_sync+h_back clocks. In clocks counted from the line start, hsync is asserted for columns h_active+h_front up to h_active+h_front+h_sync-1.
- R2: A frame lasts v_active+v_front+v_sync+v_back lines. vsync is asserted for the whole of lines v_active+v_front up to v_active+v_front+v_sync-1.
- R3: de is asserted only when the column is below h_active and the row is below v_active. While de is asserted, pix_x and pix_y give the column and row; otherwise both read 0.
- R4: Bits of pol_invert are assigned as follows: bit 0 inverts hsync, bit 1 inverts vsync, bit 2 inverts de, and bit 3 drives pclk_invert. With a bit at 0 the matching strobe is active high. The inversion is applied when idle too.
- R5: While idle, a write of 1 to the enable (en_we with en_wdata=1) copies the working set into the active set. The clock after that write shows pixel (0,0), and en_status reads 1.
- R6: A pulse on load_req sets load_pending. While running, the working set is copied into the active set on the clock where the raster sits at column 0 of row v_active (the first pixel of the vertical front porch). load_pending then clears, and the next pixel follows the new timing.
- R7: A write of 0 to the enable lets the current frame finish. en_status stays 1 through the last pixel of that frame and drops on the next clock, and all strobes go inactive.
- R8: vbl_status sets on the clock the raster leaves column 0 of row v_active. A pulse on vbl_clear clears it. If setting and clearing fall on the same clock, setting wins.
- R9: vbl_irq is high exactly when vbl_status and vbl_irq_en are both 1.
- R10: After rst_n, or one clock after soft_rst is high, the block is idle. en_status, load_pending and vbl_status are 0, the active set and its inversion bits are cleared, and all strobes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous return to idle |
| h_active | input | H_BITS | Visible pixels per line (working set) |
| h_front | input | H_BITS | Horizontal front porch in clocks |
| h_sync | input | H_BITS | Horizontal sync pulse width in clocks |
| h_back | input | H_BITS | Horizontal back porch in clocks |
| v_active | input | V_BITS | Visible lines per frame |
| v_front | input | V_BITS | Vertical front porch in lines |
| v_sync | input | V_BITS | Vertical sync pulse width in lines |
| v_back | input | V_BITS | Vertical back porch in lines |
| pol_invert | input | 4 | Inversion bits: 0 hsync, 1 vsync, 2 de, 3 pixel clock edge |
| load_req | input | 1 | Pulse: request shadow load at the next frame boundary |
| en_we | input | 1 | Pulse: write enable for the controller enable |
| en_wdata | input | 1 | Value written to the controller enable |
| vbl_irq_en | input | 1 | Vertical blanking interrupt enable |
| vbl_clear | input | 1 | Pulse: write 1 to clear vbl_status |
| en_status | output | 1 | Raster running; stays 1 until the frame ends |
| load_pending | output | 1 | Shadow load requested but not done |
| vbl_status | output | 1 | Vertical blanking status |
| vbl_irq | output | 1 | Vertical blanking interrupt |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pclk_invert | output | 1 | Selects the falling pixel clock edge for data launch |
| pix_x | output | H_BITS | Column of the visible pixel |
| pix_y | output | V_BITS | Row of the visible pixel |

## Verification
The raster is run with four timing sets, and every pixel of a full frame plus the wrap pixel is compared with a model. The four sets are an unbalanced mode, a small mode with all inversions on, a wide mode with mixed inversions, and a mode where every interval is one clock. These sets tell apart off-by-one errors at each interval boundary, swapped horizontal and vertical decoding, and polarity bits mapped to the wrong strobe. Directed runs then change the mode mid-frame through a shadow load. In the new mode the blanking row of the old one is visible, so a load taken at the wrong pixel or not taken at all shows up as a wrong de and coordinate. Further directed runs count the clocks the enable takes to drop after a disable, and exercise the clear-on-write status, the interrupt gating and the soft reset.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

    localparam int POL_N   = 4;
    localparam int POL_HS  = 0;
    localparam int POL_VS  = 1;
    localparam int POL_DE  = 2;
    localparam int POL_CLK = 3;
endpackage

// File: rtl/dtg_shadow.sv
module dtg_shadow #(
    parameter int H_BITS = 12,
    parameter int V_BITS = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     srst,
    input  logic                     load,
    input  logic                     req_wr,
    input  logic [H_BITS-1:0]        w_h_act,
    input  logic [H_BITS-1:0]        w_h_fp,
    input  logic [H_BITS-1:0]        w_h_pw,
    input  logic [H_BITS-1:0]        w_h_bp,
    input  logic [V_BITS-1:0]        w_v_act,
    input  logic [V_BITS-1:0]        w_v_fp,
    input  logic [V_BITS-1:0]        w_v_pw,
    input  logic [V_BITS-1:0]        w_v_bp,
    input  logic [dtg_pkg::POL_N-1:0] w_inv,
    output logic                     pending,
    output logic [H_BITS-1:0]        a_h_act,
    output logic [H_BITS-1:0]        a_h_fp,
    output logic [H_BITS-1:0]        a_h_pw,
    output logic [H_BITS-1:0]        a_h_bp,
    output logic [V_BITS-1:0]        a_v_act,
    output logic [V_BITS-1:0]        a_v_fp,
    output logic [V_BITS-1:0]        a_v_pw,
    output logic [V_BITS-1:0]        a_v_bp,
    output logic [dtg_pkg::POL_N-1:0] a_inv
);
    typedef struct packed {
        logic                      pending;
        logic [H_BITS-1:0]         h_act;
        logic [H_BITS-1:0]         h_fp;
        logic [H_BITS-1:0]         h_pw;
        logic [H_BITS-1:0]         h_bp;
        logic [V_BITS-1:0]         v_act;
        logic [V_BITS-1:0]         v_fp;
        logic [V_BITS-1:0]         v_pw;
        logic [V_BITS-1:0]         v_bp;
        logic [dtg_pkg::POL_N-1:0] inv;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.h_act = w_h_act;
            s_d.h_fp  = w_h_fp;
            s_d.h_pw  = w_h_pw;
            s_d.h_bp  = w_h_bp;
            s_d.v_act = w_v_act;
            s_d.v_fp  = w_v_fp;
            s_d.v_pw  = w_v_pw;
            s_d.v_bp  = w_v_bp;
            s_d.inv   = w_inv;
        end
        // a new request on the load clock is kept for the next boundary
        s_d.pending = (s_q.pending && !load) || req_wr;
        if (srst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pending = s_q.pending;
    assign a_h_act = s_q.h_act;
    assign a_h_fp  = s_q.h_fp;
    assign a_h_pw  = s_q.h_pw;
    assign a_h_bp  = s_q.h_bp;
    assign a_v_act = s_q.v_act;
    assign a_v_fp  = s_q.v_fp;
    assign a_v_pw  = s_q.v_pw;
    assign a_v_bp  = s_q.v_bp;
    assign a_inv   = s_q.inv;
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster #(
    parameter int H_BITS = 12,
    parameter int V_BITS = 12,
    localparam int CW = H_BITS + 2,
    localparam int CV = V_BITS + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic [H_BITS-1:0] h_act,
    input  logic [H_BITS-1:0] h_fp,
    input  logic [H_BITS-1:0] h_pw,
    input  logic [H_BITS-1:0] h_bp,
    input  logic [V_BITS-1:0] v_act,
    input  logic [V_BITS-1:0] v_fp,
    input  logic [V_BITS-1:0] v_pw,
    input  logic [V_BITS-1:0] v_bp,
    output logic              running,
    output logic              start,
    output logic              vfp_entry,
    output logic [CW-1:0]     h_pos,
    output logic [CV-1:0]     v_pos,
    output logic [CW-1:0]     h_tot,
    output logic [CV-1:0]     v_tot
);
    typedef struct packed {
        logic          en_req;
        logic          running;
        logic [CW-1:0] h;
        logic [CV-1:0] v;
    } raster_t;

    raster_t s_d, s_q;
    logic    h_last, v_last;

    assign h_tot = CW'(h_act) + CW'(h_fp) + CW'(h_pw) + CW'(h_bp);
    assign v_tot = CV'(v_act) + CV'(v_fp) + CV'(v_pw) + CV'(v_bp);
    // >= keeps the wrap safe when a shadow load shrinks the frame under the counter
    assign h_last = (s_q.h >= h_tot - CW'(1));
    assign v_last = (s_q.v >= v_tot - CV'(1));
    assign vfp_entry = s_q.running && (s_q.h == '0) && (s_q.v == CV'(v_act));

    always_comb begin
        s_d   = s_q;
        start = en_wr && en_wdata && !s_q.running && !srst;
        if (en_wr) begin
            s_d.en_req = en_wdata;
        end
        if (s_q.running) begin
            if (h_last) begin
                s_d.h = '0;
                if (v_last) begin
                    s_d.v = '0;
                    if (!s_d.en_req) begin
                        s_d.running = 1'b0;
                    end
                end else begin
                    s_d.v = s_q.v + CV'(1);
                end
            end else begin
                s_d.h = s_q.h + CW'(1);
            end
        end
        if (start) begin
            s_d.running = 1'b1;
            s_d.h       = '0;
            s_d.v       = '0;
        end
        if (srst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign running = s_q.running;
    assign h_pos   = s_q.h;
    assign v_pos   = s_q.v;
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode #(
    parameter int H_BITS = 12,
    parameter int V_BITS = 12,
    localparam int CW = H_BITS + 2,
    localparam int CV = V_BITS + 2,
    localparam int PW = ((H_BITS > V_BITS) ? H_BITS : V_BITS) + 2
) (
    input  logic                      running,
    input  logic [CW-1:0]             h_pos,
    input  logic [CV-1:0]             v_pos,
    input  logic [H_BITS-1:0]         h_act,
    input  logic [H_BITS-1:0]         h_fp,
    input  logic [H_BITS-1:0]         h_pw,
    input  logic [V_BITS-1:0]         v_act,
    input  logic [V_BITS-1:0]         v_fp,
    input  logic [V_BITS-1:0]         v_pw,
    input  logic [dtg_pkg::POL_N-1:0] inv,
    output logic                      de_raw,
    output logic                      hs_raw,
    output logic                      vs_raw,
    output logic [dtg_pkg::POL_N-1:0] strobes,
    output logic [H_BITS-1:0]         x,
    output logic [V_BITS-1:0]         y
);
    import dtg_pkg::*;

    function automatic seg_e classify(input logic [PW-1:0] pos, input logic [PW-1:0] act,
                                      input logic [PW-1:0] fp, input logic [PW-1:0] pw);
        seg_e s;
        if (pos < act) begin
            s = SEG_ACTIVE;
        end else if (pos < act + fp) begin
            s = SEG_FRONT;
        end else if (pos < act + fp + pw) begin
            s = SEG_SYNC;
        end else begin
            s = SEG_BACK;
        end
        return s;
    endfunction

    logic [PW-1:0] pos_a [2];
    logic [PW-1:0] act_a [2];
    logic [PW-1:0] fp_a  [2];
    logic [PW-1:0] pw_a  [2];
    seg_e          seg   [2];
    logic [POL_N-1:0] raw;

    assign pos_a[0] = PW'(h_pos);
    assign act_a[0] = PW'(h_act);
    assign fp_a[0]  = PW'(h_fp);
    assign pw_a[0]  = PW'(h_pw);
    assign pos_a[1] = PW'(v_pos);
    assign act_a[1] = PW'(v_act);
    assign fp_a[1]  = PW'(v_fp);
    assign pw_a[1]  = PW'(v_pw);

    for (genvar a = 0; a < 2; a++) begin : g_axis
        assign seg[a] = classify(pos_a[a], act_a[a], fp_a[a], pw_a[a]);
    end

    assign de_raw = running && (seg[0] == SEG_ACTIVE) && (seg[1] == SEG_ACTIVE);
    assign hs_raw = running && (seg[0] == SEG_SYNC);
    assign vs_raw = running && (seg[1] == SEG_SYNC);

    always_comb begin
        raw          = '0;
        raw[POL_HS]  = hs_raw;
        raw[POL_VS]  = vs_raw;
        raw[POL_DE]  = de_raw;
        raw[POL_CLK] = 1'b0;
    end

    for (genvar i = 0; i < POL_N; i++) begin : g_pol
        assign strobes[i] = raw[i] ^ inv[i];
    end

    assign x = de_raw ? h_pos[H_BITS-1:0] : '0;
    assign y = de_raw ? v_pos[V_BITS-1:0] : '0;
endmodule

// File: rtl/dtg_vblank.sv
module dtg_vblank (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic status,
    output logic irq
);
    typedef struct packed {
        logic status;
    } vbl_t;

    vbl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.status = 1'b0;
        end
        if (set) begin
            s_d.status = 1'b1;
        end
        if (srst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.status;
    assign irq    = s_q.status && ie;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
    parameter int H_BITS = 12,
    parameter int V_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [H_BITS-1:0] h_active,
    input  logic [H_BITS-1:0] h_front,
    input  logic [H_BITS-1:0] h_sync,
    input  logic [H_BITS-1:0] h_back,
    input  logic [V_BITS-1:0] v_active,
    input  logic [V_BITS-1:0] v_front,
    input  logic [V_BITS-1:0] v_sync,
    input  logic [V_BITS-1:0] v_back,
    input  logic [3:0]        pol_invert,
    input  logic              load_req,
    input  logic              en_we,
    input  logic              en_wdata,
    input  logic              vbl_irq_en,
    input  logic              vbl_clear,
    output logic              en_status,
    output logic              load_pending,
    output logic              vbl_status,
    output logic              vbl_irq,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_invert,
    output logic [H_BITS-1:0] pix_x,
    output logic [V_BITS-1:0] pix_y
);
    import dtg_pkg::*;

    localparam int CW = H_BITS + 2;
    localparam int CV = V_BITS + 2;

    logic [H_BITS-1:0] a_h_act, a_h_fp, a_h_pw, a_h_bp;
    logic [V_BITS-1:0] a_v_act, a_v_fp, a_v_pw, a_v_bp;
    logic [POL_N-1:0]  a_inv;
    logic [POL_N-1:0]  strobes;
    logic              running, start_pulse, vfp_entry, shadow_load;
    logic              de_raw, hs_raw, vs_raw;
    logic [CW-1:0]     h_pos, h_total;
    logic [CV-1:0]     v_pos, v_total;

    assign shadow_load = start_pulse || (vfp_entry && load_pending);

    dtg_shadow #(.H_BITS(H_BITS), .V_BITS(V_BITS)) u_shadow (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst), .load(shadow_load), .req_wr(load_req),
        .w_h_act(h_active), .w_h_fp(h_front), .w_h_pw(h_sync), .w_h_bp(h_back),
        .w_v_act(v_active), .w_v_fp(v_front), .w_v_pw(v_sync), .w_v_bp(v_back),
        .w_inv(pol_invert), .pending(load_pending),
        .a_h_act(a_h_act), .a_h_fp(a_h_fp), .a_h_pw(a_h_pw), .a_h_bp(a_h_bp),
        .a_v_act(a_v_act), .a_v_fp(a_v_fp), .a_v_pw(a_v_pw), .a_v_bp(a_v_bp),
        .a_inv(a_inv)
    );

    dtg_raster #(.H_BITS(H_BITS), .V_BITS(V_BITS)) u_raster (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst), .en_wr(en_we), .en_wdata(en_wdata),
        .h_act(a_h_act), .h_fp(a_h_fp), .h_pw(a_h_pw), .h_bp(a_h_bp),
        .v_act(a_v_act), .v_fp(a_v_fp), .v_pw(a_v_pw), .v_bp(a_v_bp),
        .running(running), .start(start_pulse), .vfp_entry(vfp_entry),
        .h_pos(h_pos), .v_pos(v_pos), .h_tot(h_total), .v_tot(v_total)
    );

    dtg_decode #(.H_BITS(H_BITS), .V_BITS(V_BITS)) u_decode (
        .running(running), .h_pos(h_pos), .v_pos(v_pos),
        .h_act(a_h_act), .h_fp(a_h_fp), .h_pw(a_h_pw),
        .v_act(a_v_act), .v_fp(a_v_fp), .v_pw(a_v_pw),
        .inv(a_inv), .de_raw(de_raw), .hs_raw(hs_raw), .vs_raw(vs_raw),
        .strobes(strobes), .x(pix_x), .y(pix_y)
    );

    dtg_vblank u_vblank (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst), .set(vfp_entry), .clr(vbl_clear),
        .ie(vbl_irq_en), .status(vbl_status), .irq(vbl_irq)
    );

    assign en_status   = running;
    assign hsync       = strobes[POL_HS];
    assign vsync       = strobes[POL_VS];
    assign de          = strobes[POL_DE];
    assign pclk_invert = strobes[POL_CLK];
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int CW = 14,
    parameter int CV = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srst,
    input logic          en_status,
    input logic          load_pending,
    input logic          load_req,
    input logic          vfp_entry,
    input logic          vbl_status,
    input logic          vbl_clear,
    input logic          de_raw,
    input logic          hs_raw,
    input logic          vs_raw,
    input logic [CW-1:0] h_pos,
    input logic [CV-1:0] v_pos,
    input logic [CW-1:0] h_total,
    input logic [CV-1:0] v_total
);
    // R1: the column never leaves the line while running
    a_r1_col_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (en_status && !$past(load_pending)) |-> (h_pos < h_total));

    // R3: visible area never overlaps either sync interval
    a_r3_de_vs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({de_raw, hs_raw}) && $onehot0({de_raw, vs_raw}));

    // R6: a pending load completes at the front-porch entry
    a_r6_pending_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pending && vfp_entry && !load_req) |=> !load_pending);

    // R7: running only stops after the last pixel of a frame
    a_r7_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_status) && !$past(srst)) |->
        ($past(h_pos) >= $past(h_total) - CW'(1) && $past(v_pos) >= $past(v_total) - CV'(1)));

    // R8: entering the front porch sets the blanking status
    a_r8_vbl_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (vfp_entry && !srst) |=> vbl_status);

    // R8: clear-on-write wins unless a set coincides
    a_r8_vbl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vbl_clear && !vfp_entry) |=> !vbl_status);

    // R10: soft reset idles the block
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!en_status && !load_pending && !vbl_status));
endmodule

bind disp_timing_gen dtg_checker #(.CW(H_BITS + 2), .CV(V_BITS + 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .en_status(en_status),
    .load_pending(load_pending), .load_req(load_req), .vfp_entry(vfp_entry),
    .vbl_status(vbl_status), .vbl_clear(vbl_clear), .de_raw(de_raw),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .h_pos(h_pos), .v_pos(v_pos),
    .h_total(h_total), .v_total(v_total)
);

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
    localparam int HB = 12;
    localparam int VB = 12;

    typedef struct packed {
        logic [7:0]  ha, hf, hp, hb, va, vf, vp, vb;
        logic [3:0]  inv;
        logic [15:0] frame;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{8'd8,  8'd2, 8'd3, 8'd4, 8'd5, 8'd1, 8'd2, 8'd2, 4'b0000, 16'd170},
        '{8'd4,  8'd1, 8'd1, 8'd1, 8'd3, 8'd2, 8'd1, 8'd1, 4'b1111, 16'd49},
        '{8'd16, 8'd3, 8'd5, 8'd2, 8'd4, 8'd1, 8'd3, 8'd2, 4'b0101, 16'd260},
        '{8'd1,  8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 4'b1010, 16'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic [HB-1:0] h_active = '0, h_front = '0, h_sync = '0, h_back = '0;
    logic [VB-1:0] v_active = '0, v_front = '0, v_sync = '0, v_back = '0;
    logic [3:0] pol_invert = '0;
    logic load_req = 1'b0, en_we = 1'b0, en_wdata = 1'b0;
    logic vbl_irq_en = 1'b0, vbl_clear = 1'b0;
    logic en_status, load_pending, vbl_status, vbl_irq;
    logic hsync, vsync, de, pclk_invert;
    logic [HB-1:0] pix_x;
    logic [VB-1:0] pix_y;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    disp_timing_gen #(.H_BITS(HB), .V_BITS(VB)) u_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .h_active(h_active), .h_front(h_front), .h_sync(h_sync), .h_back(h_back),
        .v_active(v_active), .v_front(v_front), .v_sync(v_sync), .v_back(v_back),
        .pol_invert(pol_invert), .load_req(load_req), .en_we(en_we), .en_wdata(en_wdata),
        .vbl_irq_en(vbl_irq_en), .vbl_clear(vbl_clear), .en_status(en_status),
        .load_pending(load_pending), .vbl_status(vbl_status), .vbl_irq(vbl_irq),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk_invert(pclk_invert),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    task automatic set_cfg(input vec_t v);
        h_active = HB'(v.ha); h_front = HB'(v.hf); h_sync = HB'(v.hp); h_back = HB'(v.hb);
        v_active = VB'(v.va); v_front = VB'(v.vf); v_sync = VB'(v.vp); v_back = VB'(v.vb);
        pol_invert = v.inv;
    endtask

    task automatic pulse_srst();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    // leaves the caller on the negedge that shows pixel (0,0)
    task automatic start_ctrl(input vec_t v);
        @(negedge clk);
        set_cfg(v);
        en_we = 1'b1; en_wdata = 1'b1;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 en_status after reset", int'(en_status), 0);
        chk("R10 load_pending after reset", int'(load_pending), 0);
        chk("R10 vbl_status after reset", int'(vbl_status), 0);
        chk("R10 strobes after reset", int'({hsync, vsync, de, pclk_invert, vbl_irq}), 0);

        // Table walk: R1 R2 R3 R4 R5 over full frames plus wrap pixel
        for (int k = 0; k < 4; k++) begin
            vec_t v;
            int htot, vtot, e_hs, e_vs, e_de, e_xy, e_ck;
            v = VECS[k];
            htot = int'(v.ha) + int'(v.hf) + int'(v.hp) + int'(v.hb);
            vtot = int'(v.va) + int'(v.vf) + int'(v.vp) + int'(v.vb);
            e_hs = 0; e_vs = 0; e_de = 0; e_xy = 0; e_ck = 0;
            pulse_srst();
            start_ctrl(v);
            chk("R5 en_status after start", int'(en_status), 1);
            for (int i = 0; i <= int'(v.frame); i++) begin
                int p, hx, vy;
                bit xd, xh, xv;
                p  = i % int'(v.frame);
                hx = p % htot;
                vy = p / htot;
                xd = (hx < int'(v.ha)) && (vy < int'(v.va));
                xh = (hx >= int'(v.ha) + int'(v.hf)) && (hx < int'(v.ha) + int'(v.hf) + int'(v.hp));
                xv = (vy >= int'(v.va) + int'(v.vf)) && (vy < int'(v.va) + int'(v.vf) + int'(v.vp));
                if (hsync !== (xh ^ v.inv[0])) e_hs++;
                if (vsync !== (xv ^ v.inv[1])) e_vs++;
                if (de !== (xd ^ v.inv[2])) e_de++;
                if (pclk_invert !== v.inv[3]) e_ck++;
                if (int'(pix_x) != (xd ? hx : 0) || int'(pix_y) != (xd ? vy : 0)) e_xy++;
                @(negedge clk);
            end
            chk($sformatf("R1 R4 hsync mismatches vec%0d", k), e_hs, 0);
            chk($sformatf("R2 R4 vsync mismatches vec%0d", k), e_vs, 0);
            chk($sformatf("R3 R4 de mismatches vec%0d", k), e_de, 0);
            chk($sformatf("R3 coordinate mismatches vec%0d", k), e_xy, 0);
            chk($sformatf("R4 pclk_invert mismatches vec%0d", k), e_ck, 0);
        end

        // R6 R8 R9: shadow load mid-frame, blanking status and interrupt
        pulse_srst();
        start_ctrl(VECS[0]);
        h_active = 12'd6; h_front = 12'd2; h_sync = 12'd2; h_back = 12'd2;
        v_active = 12'd8; v_front = 12'd2; v_sync = 12'd1; v_back = 12'd1;
        pol_invert = 4'b0000;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        chk("R6 load_pending after request", int'(load_pending), 1);
        repeat (84) @(negedge clk);
        chk("R6 load_pending held before boundary", int'(load_pending), 1);
        chk("R8 vbl_status before boundary", int'(vbl_status), 0);
        @(negedge clk);
        chk("R6 load_pending cleared at boundary", int'(load_pending), 0);
        chk("R6 new timing shows visible row", int'(de), 1);
        chk("R6 new timing pix_x", int'(pix_x), 1);
        chk("R6 new timing pix_y", int'(pix_y), 5);
        chk("R8 vbl_status set", int'(vbl_status), 1);
        chk("R9 irq masked by enable", int'(vbl_irq), 0);
        vbl_irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq with enable", int'(vbl_irq), 1);
        vbl_clear = 1'b1;
        @(negedge clk);
        vbl_clear = 1'b0;
        chk("R8 vbl_status cleared by write", int'(vbl_status), 0);
        chk("R9 irq follows clear", int'(vbl_irq), 0);
        vbl_irq_en = 1'b0;

        // R7: disable handshake lasts to the end of the frame
        pulse_srst();
        start_ctrl(VECS[3]);
        en_we = 1'b1; en_wdata = 1'b0;
        @(negedge clk);
        en_we = 1'b0;
        begin
            int ones = 0;
            for (int i = 0; i < 40; i++) begin
                if (en_status) ones++;
                @(negedge clk);
            end
            chk("R7 clocks en_status stays set after disable", ones, 15);
        end
        chk("R7 en_status dropped", int'(en_status), 0);
        chk("R7 de inactive after stop", int'(de), 0);

        // R5 restart, then R10 soft reset mid-frame
        start_ctrl(VECS[0]);
        chk("R5 restart en_status", int'(en_status), 1);
        chk("R5 restart first pixel de", int'(de), 1);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R10 en_status after soft reset", int'(en_status), 0);
        chk("R10 load_pending after soft reset", int'(load_pending), 0);
        chk("R10 strobes after soft reset", int'({hsync, vsync, de, pclk_invert}), 0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule